// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block forms the second ALU operand of a 32-bit RISC data path. It takes a data word, a three-bit shift-kind code, a shift amount and the current carry flag. It returns the shifted word together with the shifter carry that a flag-setting logical operation would use. Five shift kinds are supported:

- logical left
- logical right
- arithmetic right
- rotate right
- a one-bit rotate right through the carry flag

Each kind has its own rule for the carry-out when the amount is zero, exactly the word width, or larger than the word width.

The shifting is purely combinational. An optional output register, selected by a parameter and enabled by default, adds exactly one cycle of latency. The register file, operand selection, the ALU and flag writeback all sit outside this block.

Top module: `barrel_shifter`

## Requirements
- R1: The shift-kind code selects the operation: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right through carry.
- R2: Only amount bits 7:0 take part in the operation. Any value on the higher amount bits leaves the result and carry-out unchanged.
- R3: For kinds 0 to 3, an amount of zero returns the operand unchanged, and the carry-out equals the carry input.
- R4: For logical left and logical right with an amount from 1 to 31, the result is the shifted operand and the carry-out is the last bit shifted out. Logical left uses operand bit 32-n; logical right uses operand bit n-1.
- R5: A logical left by exactly 32 gives result 0 with carry-out equal to operand bit 0. A logical right by exactly 32 gives result 0 with carry-out equal to operand bit 31.
- R6: A logical left or logical right by more than 32 gives result 0 and carry-out 0.
- R7: An arithmetic right by 1 to 31 fills the vacated bits with operand bit 31, and the carry-out is operand bit n-1.
- R8: An arithmetic right by 32 or more gives every result bit equal to operand bit 31, and the carry-out is equal to operand bit 31.
- R9: A rotate right by a nonzero amount rotates by the amount modulo 32, and the carry-out is result bit 31. A nonzero multiple of 32 returns the operand unchanged.
- R10: Kind 4 ignores the amount, including zero. The result is the operand shifted right by one with the carry input placed at bit 31, and the carry-out is the old operand bit 0.
- R11: Kinds 5, 6 and 7 return the operand unchanged, and the carry-out equals the carry input.
- R12: With the output register enabled, the outputs show the result for the inputs presented one clock earlier. While reset is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset; clears the output register |
| opnd_i | input | 32 | Operand to be shifted |
| kind_i | input | 3 | Shift-kind code |
| amt_i | input | 12 | Shift amount; only bits 7:0 are used |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted result |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Two rules apply in the same cycle: the amount-boundary selection (zero, below 32, exactly 32, above 32) and the carry-out source, which can be the carry input, an operand bit, a result bit, or a constant 0. The bench sweeps every 8-bit amount for all eight kind codes, with both carry-input values and several operand patterns. Each vector also carries junk on the high amount bits. This drives the boundary cases 0, 31, 32, 33, 64 and 255 against both carry values. Every vector is judged one cycle later against a wide-word arithmetic model held in the bench.

// File: rtl/barrel_shifter.sv
module barrel_shifter #(
  parameter int DATA_W   = 32,
  parameter int AMT_IN_W = 12,
  parameter bit REG_OUT  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DATA_W-1:0]   opnd_i,
  input  logic [2:0]          kind_i,
  input  logic [AMT_IN_W-1:0] amt_i,
  input  logic                carry_i,
  output logic [DATA_W-1:0]   result_o,
  output logic                carry_o
);
  localparam int AMT_W = 8;
  localparam int ROT_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] FULL = AMT_W'(DATA_W);

  localparam logic [2:0] K_LSL = 3'd0;
  localparam logic [2:0] K_LSR = 3'd1;
  localparam logic [2:0] K_ASR = 3'd2;
  localparam logic [2:0] K_ROR = 3'd3;
  localparam logic [2:0] K_RRX = 3'd4;

  logic [AMT_W-1:0]    amt;
  logic                unused_amt_hi;
  logic [ROT_W-1:0]    rot, lo_idx, hi_idx;
  logic [2*DATA_W-1:0] twin;
  logic [DATA_W-1:0]   sh_res;
  logic                sh_c;
  logic                sign;

  assign amt           = amt_i[AMT_W-1:0];
  assign unused_amt_hi = ^amt_i[AMT_IN_W-1:AMT_W];
  assign rot           = amt[ROT_W-1:0];
  assign lo_idx        = rot - 1'b1;
  assign hi_idx        = ROT_W'(DATA_W) - rot;
  assign twin          = {opnd_i, opnd_i} >> rot;
  assign sign          = opnd_i[DATA_W-1];

  always_comb begin
    sh_res = opnd_i;
    sh_c   = carry_i;
    case (kind_i)
      K_LSL: if (amt != '0) begin
        if (amt < FULL) begin
          sh_res = opnd_i << amt;
          sh_c   = opnd_i[hi_idx];
        end else if (amt == FULL) begin
          sh_res = '0;
          sh_c   = opnd_i[0];
        end else begin
          sh_res = '0;
          sh_c   = 1'b0;
        end
      end
      K_LSR: if (amt != '0) begin
        if (amt < FULL) begin
          sh_res = opnd_i >> amt;
          sh_c   = opnd_i[lo_idx];
        end else if (amt == FULL) begin
          sh_res = '0;
          sh_c   = sign;
        end else begin
          sh_res = '0;
          sh_c   = 1'b0;
        end
      end
      K_ASR: if (amt != '0) begin
        if (amt < FULL) begin
          sh_res = DATA_W'($signed(opnd_i) >>> amt);
          sh_c   = opnd_i[lo_idx];
        end else begin
          sh_res = {DATA_W{sign}};
          sh_c   = sign;
        end
      end
      K_ROR: if (amt != '0) begin
        sh_res = twin[DATA_W-1:0];
        sh_c   = twin[DATA_W-1];
      end
      K_RRX: begin
        sh_res = {carry_i, opnd_i[DATA_W-1:1]};
        sh_c   = opnd_i[0];
      end
      default: ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          result_o <= '0;
          carry_o  <= 1'b0;
        end else begin
          result_o <= sh_res;
          carry_o  <= sh_c;
        end
      end

      a_r12_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (result_o == $past(sh_res) && carry_o == $past(sh_c)));
    end else begin : g_comb
      assign result_o = sh_res;
      assign carry_o  = sh_c;
    end
  endgenerate

  a_r11_reserved_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i > K_RRX) |-> (sh_res == opnd_i && sh_c == carry_i));

  a_r6_big_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind_i == K_LSL || kind_i == K_LSR) && amt > FULL) |-> (sh_res == '0 && !sh_c));

  a_r8_asr_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_ASR && amt >= FULL) |-> (sh_res == {DATA_W{sign}} && sh_c == sign));

  a_r9_ror_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_ROR && amt != '0) |-> (sh_c == sh_res[DATA_W-1]));

  a_r10_rrx: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i == K_RRX) |-> (sh_c == opnd_i[0] && sh_res[DATA_W-1] == carry_i));

  a_r3_zero_amt: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_i < K_RRX && amt == '0) |-> (sh_res == opnd_i && sh_c == carry_i));
endmodule

// File: tb/tb_barrel_shifter.sv
module tb_barrel_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opnd_i = '0;
  logic [2:0]  kind_i = '0;
  logic [11:0] amt_i = '0;
  logic        carry_i = 1'b0;
  logic [31:0] result_o;
  logic        carry_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  barrel_shifter dut (
    .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .kind_i(kind_i),
    .amt_i(amt_i), .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o)
  );

  function automatic logic [32:0] model(logic [31:0] op, logic [2:0] k, logic [7:0] n, logic ci);
    logic [64:0] wl;
    logic [63:0] wr;
    logic [63:0] dr;
    logic [31:0] r;
    logic        c;
    r = op; c = ci;
    case (k)
      3'd0: if (n != 0) begin wl = {33'b0, op} << n; r = wl[31:0]; c = wl[32]; end
      3'd1: if (n != 0) begin wr = {op, 32'b0} >> n; r = wr[63:32]; c = (n <= 32) ? wr[31] : 1'b0; end
      3'd2: if (n != 0) begin wr = $signed({op, 32'b0}) >>> n; r = wr[63:32]; c = wr[31]; end
      3'd3: if (n != 0) begin dr = {op, op} >> (n % 32); r = dr[31:0]; c = r[31]; end
      3'd4: begin r = {ci, op[31:1]}; c = op[0]; end
      default: ;
    endcase
    return {c, r};
  endfunction

  function automatic string req_of(logic [2:0] k, logic [7:0] n);
    if (k > 3'd4) return "R11";
    if (k == 3'd4) return "R10";
    if (n == 0) return "R3";
    if (k == 3'd3) return "R9";
    if (k == 3'd2) return (n >= 32) ? "R8" : "R7";
    if (n == 32) return "R5";
    if (n > 32) return "R6";
    return "R4";
  endfunction

  task automatic check(string req, logic [32:0] got, logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got c=%0b r=%h, expected c=%0b r=%h", req, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  initial begin
    logic [31:0] pats [8];
    logic [32:0] exp;
    string       rq;
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h8000_0000; pats[3] = 32'h0000_0001;
    pats[4] = 32'h1234_5678; pats[5] = 32'h8765_4321;
    pats[6] = 32'hA5A5_A5A5; pats[7] = 32'h5A5A_5A5B;

    opnd_i = 32'hDEAD_BEEF; kind_i = 3'd0; amt_i = 12'd4; carry_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R12", {carry_o, result_o}, 33'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int p = 0; p < 8; p++)
      for (int k = 0; k < 8; k++)
        for (int ci = 0; ci < 2; ci++)
          for (int n = 0; n < 256; n++) begin
            opnd_i  = pats[p];
            kind_i  = 3'(k);
            carry_i = ci[0];
            amt_i   = {4'((n * 7 + p + k) ^ 4'hA), 8'(n)};
            exp     = model(pats[p], 3'(k), 8'(n), ci[0]);
            rq      = req_of(3'(k), 8'(n));
            @(negedge clk);
            // R1 R2 R12: kind decode, high amount bits junk, one-cycle latency
            check(rq, {carry_o, result_o}, exp);
          end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (60000) @(posedge clk); checks++; fails++; $display("FAIL watchdog: got hang, expected completion"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule